// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control core of a small accumulator machine. It steps each instruction through a fixed series of subcycles. A fetch reads the instruction word. An indirect subcycle runs only when the instruction asks for one and reads a pointer. An execute subcycle performs the register transfer or ALU step. An interrupt subcycle runs between instructions. The block holds the program counter, the instruction opcode, the memory address and buffer registers, the accumulator and a status word. All traffic goes through one memory port, which uses a request/ready handshake.

The memory port may stretch any access by any number of wait states. After each completed instruction, a pending interrupt request is accepted only if interrupts are enabled. The core then writes the program counter to a fixed save location and continues at a fixed handler address. A return opcode reloads the counter from that location. The current subcycle is brought out for debug, and the status word is brought out so that the condition bits can be observed.

Top module: `seq_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, the subcycle output is 0 and no request is made. The status word is 0x20, which means only interrupt-enable is set. The first fetch reads address RESET_PC (default 0).
- R2: Once the request is raised, it stays high until ready is returned. Address, write data and write-enable do not change while it waits. Write-enable is only ever high together with the request. Any number of wait states gives the same results.
- R3: An instruction word is laid out as bits [15:12] opcode, bit [11] indirect flag and bits [10:0] address field. A fetch reads the word at PC, and PC then advances by one.
- R4: The indirect subcycle (subcycle code 1) runs only for opcodes 1 to 7 with bit 11 set. It reads the word at the address field, and that word's low 11 bits become the effective address. No other instruction enters it.
- R5: Opcode 1 loads the word at the effective address into the accumulator. Opcode 2 writes the accumulator to the effective address.
- R6: Opcodes 3, 4 and 5 add, subtract or AND the word at the effective address into the accumulator. Each of them rewrites the condition bits of the status word: bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow, bit 4 equal. Equal is set when the accumulator matched the operand before the operation.
- R7: For add, carry is the unsigned carry out. For subtract, carry is set on a borrow. Overflow is set on signed overflow of either operation. AND clears both carry and overflow.
- R8: Opcode 6 jumps to the effective address. Opcode 7 jumps there only when the zero bit is set, and otherwise falls through.
- R9: An interrupt (subcycle code 3) is entered only right after an execute subcycle ends, and only when the request is high and interrupt-enable (status bit 5) is set. A request held while the bit is clear has no effect.
- R10: The interrupt subcycle writes the return PC to SAVE_ADDR (default 0x7F0). It clears interrupt-enable and sets supervisor (status bit 6). The next fetch then reads HANDLER_ADDR (default 0x040).
- R11: Opcode 8 reloads PC from the word at SAVE_ADDR, sets interrupt-enable and clears supervisor.
- R12: Opcodes 0 and 9 to 15 change nothing. Load, store and jumps leave the condition bits unchanged.
- R13: The subcycle output reads 0 during fetch, 1 during indirect, 2 during execute and 3 during interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | 1 | Maskable interrupt request, level |
| memReady | input | 1 | Memory completes the current access |
| memRData | input | 16 | Read data, valid with memReady |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 11 | Access address |
| memWData | output | 16 | Write data |
| subcycle | output | 2 | Current subcycle code |
| psw | output | 7 | Status word |

## Verification
Every memory access is preceded by a cycle in which the address register is loaded. A read then costs two cycles plus the wait states, and an instruction is done within about eight cycles plus the waits. The accumulator and condition bits change on the edge that ends the execute access. A store's data reaches memory in the ready cycle. The bench samples at the falling edge and checks the reset state on the first two falling edges after release. For program results, it runs a fixed number of cycles that is well past the last instruction of each short program. For interrupt checks, which depend on when the handshake ends, it waits for the subcycle or the specific store to appear before sampling.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPC_W = 4;
  localparam int PSW_W = 7;

  // status word bit positions
  localparam int PSW_C   = 0;
  localparam int PSW_Z   = 1;
  localparam int PSW_S   = 2;
  localparam int PSW_V   = 3;
  localparam int PSW_E   = 4;
  localparam int PSW_IE  = 5;
  localparam int PSW_SUP = 6;

  localparam logic [OPC_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'd4;
  localparam logic [OPC_W-1:0] OP_AND   = 4'd5;
  localparam logic [OPC_W-1:0] OP_JMP   = 4'd6;
  localparam logic [OPC_W-1:0] OP_JZ    = 4'd7;
  localparam logic [OPC_W-1:0] OP_RETI  = 4'd8;

  // upper two bits of the state form the subcycle code
  typedef enum logic [2:0] {
    ST_FETCH    = 3'd0,
    ST_FETCH_RD = 3'd1,
    ST_IND      = 3'd2,
    ST_IND_RD   = 3'd3,
    ST_EXEC     = 3'd4,
    ST_EXEC_MEM = 3'd5,
    ST_INTR     = 3'd6,
    ST_INTR_WR  = 3'd7
  } seqState_e;

  typedef enum logic [1:0] {MAR_KEEP, MAR_PC, MAR_FIELD, MAR_SAVE} marSel_e;
  typedef enum logic [1:0] {MBR_KEEP, MBR_RDATA, MBR_PC, MBR_ACC} mbrSel_e;
  typedef enum logic [2:0] {ALU_NONE, ALU_LOAD, ALU_ADD, ALU_SUB, ALU_AND} aluOp_e;

  typedef struct packed {
    marSel_e marSel;
    mbrSel_e mbrSel;
    logic    irLoad;
    logic    pcInc;
    logic    pcJump;
    logic    pcRestore;
    logic    pcHandler;
    aluOp_e  aluOp;
    logic    intEnter;
    logic    intLeave;
  } strobes_t;

  function automatic logic usesAddress(input logic [OPC_W-1:0] op);
    return (op >= OP_LOAD) && (op <= OP_JZ);
  endfunction

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = '1,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0,
  localparam int DATA_W = ADDR_W + OPC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] marOut,
  output logic [DATA_W-1:0] mbrOut,
  output logic [OPC_W-1:0]  irOut,
  output logic [PSW_W-1:0]  pswOut
);

  localparam int MSB = DATA_W - 1;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, acc;
  logic [OPC_W-1:0]  ir;
  logic [PSW_W-1:0]  psw;

  logic [DATA_W-1:0] opnd, aluRes;
  logic [DATA_W:0]   sumW, diffW;
  logic              cOut, vOut, flagWrite;

  assign opnd  = memRData;
  assign sumW  = {1'b0, acc} + {1'b0, opnd};
  assign diffW = {1'b0, acc} - {1'b0, opnd};

  always_comb begin
    aluRes    = acc;
    cOut      = 1'b0;
    vOut      = 1'b0;
    flagWrite = 1'b0;
    case (strb.aluOp)
      ALU_LOAD: aluRes = opnd;
      ALU_ADD: begin
        aluRes    = sumW[MSB:0];
        cOut      = sumW[DATA_W];
        vOut      = (acc[MSB] == opnd[MSB]) && (sumW[MSB] != acc[MSB]);
        flagWrite = 1'b1;
      end
      ALU_SUB: begin
        aluRes    = diffW[MSB:0];
        cOut      = diffW[DATA_W];
        vOut      = (acc[MSB] != opnd[MSB]) && (diffW[MSB] != acc[MSB]);
        flagWrite = 1'b1;
      end
      ALU_AND: begin
        aluRes    = acc & opnd;
        flagWrite = 1'b1;
      end
      default: aluRes = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= RESET_PC;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      psw <= PSW_W'(1) << PSW_IE;
    end else begin
      case (strb.marSel)
        MAR_PC:    mar <= pc;
        MAR_FIELD: mar <= mbr[ADDR_W-1:0];
        MAR_SAVE:  mar <= SAVE_ADDR;
        default:   mar <= mar;
      endcase

      case (strb.mbrSel)
        MBR_RDATA: mbr <= memRData;
        MBR_PC:    mbr <= DATA_W'(pc);
        MBR_ACC:   mbr <= acc;
        default:   mbr <= mbr;
      endcase

      if (strb.irLoad) ir <= memRData[MSB -: OPC_W];

      if (strb.pcHandler)      pc <= HANDLER_ADDR;
      else if (strb.pcRestore) pc <= memRData[ADDR_W-1:0];
      else if (strb.pcJump)    pc <= mbr[ADDR_W-1:0];
      else if (strb.pcInc)     pc <= pc + 1'b1;

      if (strb.aluOp != ALU_NONE) acc <= aluRes;

      if (flagWrite) begin
        psw[PSW_C] <= cOut;
        psw[PSW_Z] <= (aluRes == '0);
        psw[PSW_S] <= aluRes[MSB];
        psw[PSW_V] <= vOut;
        psw[PSW_E] <= (acc == opnd);
      end

      if (strb.intEnter) begin
        psw[PSW_IE]  <= 1'b0;
        psw[PSW_SUP] <= 1'b1;
      end else if (strb.intLeave) begin
        psw[PSW_IE]  <= 1'b1;
        psw[PSW_SUP] <= 1'b0;
      end
    end
  end

  assign marOut = mar;
  assign mbrOut = mbr;
  assign irOut  = ir;
  assign pswOut = psw;

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             memReady,
  input  logic             irqReq,
  input  logic [OPC_W:0]   fetchHdr,
  input  logic [OPC_W-1:0] irOpcode,
  input  logic             pswZero,
  input  logic             pswIe,
  output strobes_t         strb,
  output logic             memReq,
  output logic             memWe,
  output logic [1:0]       subcycle
);

  seqState_e state, nextState;
  logic [OPC_W-1:0] fetchOp;
  logic fetchInd, takeInt;

  assign fetchOp  = fetchHdr[OPC_W:1];
  assign fetchInd = fetchHdr[0];
  assign takeInt  = irqReq && pswIe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_FETCH: begin
        strb.marSel = MAR_PC;
        nextState   = ST_FETCH_RD;
      end
      ST_FETCH_RD: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.mbrSel = MBR_RDATA;
          strb.irLoad = 1'b1;
          strb.pcInc  = 1'b1;
          nextState   = (fetchInd && usesAddress(fetchOp)) ? ST_IND : ST_EXEC;
        end
      end
      ST_IND: begin
        strb.marSel = MAR_FIELD;
        nextState   = ST_IND_RD;
      end
      ST_IND_RD: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.mbrSel = MBR_RDATA;
          nextState   = ST_EXEC;
        end
      end
      ST_EXEC: begin
        case (irOpcode)
          OP_LOAD, OP_ADD, OP_SUB, OP_AND: begin
            strb.marSel = MAR_FIELD;
            nextState   = ST_EXEC_MEM;
          end
          OP_STORE: begin
            strb.marSel = MAR_FIELD;
            strb.mbrSel = MBR_ACC;
            nextState   = ST_EXEC_MEM;
          end
          OP_RETI: begin
            strb.marSel = MAR_SAVE;
            nextState   = ST_EXEC_MEM;
          end
          OP_JMP: begin
            strb.pcJump = 1'b1;
            nextState   = takeInt ? ST_INTR : ST_FETCH;
          end
          OP_JZ: begin
            strb.pcJump = pswZero;
            nextState   = takeInt ? ST_INTR : ST_FETCH;
          end
          default: nextState = takeInt ? ST_INTR : ST_FETCH;
        endcase
      end
      ST_EXEC_MEM: begin
        memReq = 1'b1;
        memWe  = (irOpcode == OP_STORE);
        if (memReady) begin
          case (irOpcode)
            OP_LOAD: strb.aluOp = ALU_LOAD;
            OP_ADD:  strb.aluOp = ALU_ADD;
            OP_SUB:  strb.aluOp = ALU_SUB;
            OP_AND:  strb.aluOp = ALU_AND;
            OP_RETI: begin
              strb.pcRestore = 1'b1;
              strb.intLeave  = 1'b1;
            end
            default: strb.aluOp = ALU_NONE;
          endcase
          nextState = takeInt ? ST_INTR : ST_FETCH;
        end
      end
      ST_INTR: begin
        strb.marSel = MAR_SAVE;
        strb.mbrSel = MBR_PC;
        nextState   = ST_INTR_WR;
      end
      ST_INTR_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          strb.pcHandler = 1'b1;
          strb.intEnter  = 1'b1;
          nextState      = ST_FETCH;
        end
      end
      default: nextState = ST_FETCH;
    endcase
  end

  assign subcycle = state[2:1];

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = 11'h7F0,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h040,
  localparam int DATA_W = ADDR_W + OPC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [1:0]        subcycle,
  output logic [PSW_W-1:0]  psw
);

  strobes_t strb;
  logic [OPC_W-1:0] irOpcode;

  seq_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memReady (memReady),
    .irqReq   (irqReq),
    .fetchHdr (memRData[DATA_W-1:ADDR_W]),
    .irOpcode (irOpcode),
    .pswZero  (psw[PSW_Z]),
    .pswIe    (psw[PSW_IE]),
    .strb     (strb),
    .memReq   (memReq),
    .memWe    (memWe),
    .subcycle (subcycle)
  );

  seq_datapath #(
    .ADDR_W       (ADDR_W),
    .RESET_PC     (RESET_PC),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memRData (memRData),
    .marOut   (memAddr),
    .mbrOut   (memWData),
    .irOut    (irOpcode),
    .pswOut   (psw)
  );

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk
  import seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int DATA_W = ADDR_W + OPC_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memReady,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic [1:0]        subcycle,
  input logic [PSW_W-1:0]  psw
);

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  a_r2_write_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  a_r4_indirect_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (subcycle == 2'd1 && $past(subcycle) != 2'd1) |-> $past(subcycle) == 2'd0);

  a_r9_interrupt_after_execute: assert property (@(posedge clk) disable iff (!rstN)
    (subcycle == 2'd3 && $past(subcycle) != 2'd3) |-> ($past(subcycle) == 2'd2 && $past(psw[PSW_IE])));

  a_r10_handler_mode: assert property (@(posedge clk) disable iff (!rstN)
    (subcycle == 2'd0 && $past(subcycle) == 2'd3) |-> (!psw[PSW_IE] && psw[PSW_SUP]));

  a_r6_flags_only_from_execute: assert property (@(posedge clk) disable iff (!rstN)
    (subcycle != 2'd2) |=> $stable(psw[PSW_E:PSW_C]));

endmodule

bind seq_core seq_core_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_seq_core.sv
module sim_seq_core;
  import seq_pkg::*;

  localparam int AW = 11;
  localparam int DW = 16;
  localparam logic [AW-1:0] SAVE = 11'h7F0;
  localparam logic [AW-1:0] HANDLER = 11'h040;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 1'b0;
  logic memReady = 1'b0;
  logic [DW-1:0] memRData = '0;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWData;
  logic [1:0] subcycle;
  logic [PSW_W-1:0] psw;

  logic [DW-1:0] mem [0:2047];
  int waitStates = 0;
  int waitCnt = 0;
  int compared = 0;
  int mismatched = 0;
  int indCycles = 0;
  int execCycles = 0;
  int intEntries = 0;
  logic [1:0] prevSub = 2'd0;
  bit done = 0;

  seq_core u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .memReady(memReady), .memRData(memRData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .subcycle(subcycle), .psw(psw)
  );

  initial forever #10 clk = ~clk;

  // memory model: answers at the falling edge after the configured wait states
  initial forever begin
    @(negedge clk);
    if (memReq && rstN) begin
      if (waitCnt >= waitStates) begin
        memReady = 1'b1;
        memRData = mem[memAddr];
        if (memWe) mem[memAddr] = memWData;
      end else begin
        waitCnt++;
        memReady = 1'b0;
      end
    end else begin
      waitCnt = 0;
      memReady = 1'b0;
    end
  end

  // observation of subcycle activity
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      if (subcycle == 2'd1) indCycles++;
      if (subcycle == 2'd2) execCycles++;
      if (subcycle == 2'd3 && prevSub != 2'd3) intEntries++;
    end
    prevSub = subcycle;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic ind, input logic [10:0] a);
    return {op, ind, a};
  endfunction

  function automatic logic [6:0] pswOf(input logic [4:0] flags);
    return {2'b01, flags};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 2048; i++) mem[i] = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    irqReq = 1'b0;
    repeat (3) @(posedge clk);
    indCycles = 0;
    execCycles = 0;
    intEntries = 0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    clearMem();
    waitStates = 0;
    doReset();
    check("R1 subcycle after reset", 32'(subcycle), 0);
    check("R1 no request after reset", 32'(memReq), 0);
    check("R1 status after reset", 32'(psw), 32'h20);
    @(negedge clk);
    check("R1 R3 first fetch request", 32'(memReq), 1);
    check("R1 R3 first fetch address", 32'(memAddr), 0);
    check("R13 fetch code", 32'(subcycle), 0);
  endtask

  task automatic testBasic(input int ws);
    clearMem();
    waitStates = ws;
    mem[0] = ins(OP_LOAD, 0, 100);
    mem[1] = ins(OP_ADD, 0, 101);
    mem[2] = ins(OP_STORE, 0, 102);
    mem[3] = ins(OP_JMP, 0, 3);
    mem[100] = 16'd5;
    mem[101] = 16'd7;
    doReset();
    runCycles(60 + 20 * ws);
    check($sformatf("R5 R2 load-add-store waits=%0d", ws), 32'(mem[102]), 12);
    check("R6 flags after 5+7", 32'(psw), 32'h20);
    check("R4 no indirect subcycle for direct words", indCycles, 0);
    check("R13 execute code seen", 32'(execCycles > 0), 1);
  endtask

  task automatic aluCase(input string tag, input logic [15:0] a, input logic [3:0] op,
                         input logic [15:0] b, input logic [15:0] expRes, input logic [4:0] expFlags);
    clearMem();
    waitStates = 1;
    mem[0] = ins(OP_LOAD, 0, 100);
    mem[1] = ins(op, 0, 101);
    mem[2] = ins(OP_STORE, 0, 110);
    mem[3] = ins(OP_JMP, 0, 3);
    mem[100] = a;
    mem[101] = b;
    doReset();
    runCycles(80);
    check({tag, " result"}, 32'(mem[110]), 32'(expRes));
    check({tag, " status"}, 32'(psw), 32'(pswOf(expFlags)));
  endtask

  task automatic testJumps();
    // R8 taken: 9-9 gives zero
    clearMem();
    waitStates = 0;
    mem[0] = ins(OP_LOAD, 0, 100);
    mem[1] = ins(OP_SUB, 0, 100);
    mem[2] = ins(OP_JZ, 0, 5);
    mem[3] = ins(OP_STORE, 0, 140);
    mem[4] = ins(OP_JMP, 0, 4);
    mem[5] = ins(OP_STORE, 0, 141);
    mem[6] = ins(OP_JMP, 0, 6);
    mem[100] = 16'd9;
    mem[140] = 16'h1111;
    mem[141] = 16'h2222;
    doReset();
    runCycles(80);
    check("R8 jz taken skips fall-through", 32'(mem[140]), 32'h1111);
    check("R8 jz taken reaches target", 32'(mem[141]), 0);
    // R8 not taken: 9-4 nonzero
    mem[1] = ins(OP_SUB, 0, 103);
    mem[103] = 16'd4;
    mem[140] = 16'h1111;
    mem[141] = 16'h2222;
    doReset();
    runCycles(80);
    check("R8 jz not taken falls through", 32'(mem[140]), 5);
    check("R8 jz not taken leaves target", 32'(mem[141]), 32'h2222);
  endtask

  task automatic testIndirect();
    clearMem();
    waitStates = 2;
    mem[0] = ins(OP_LOAD, 1, 110);
    mem[1] = ins(OP_STORE, 1, 111);
    mem[2] = ins(OP_JMP, 1, 112);
    mem[3] = ins(OP_STORE, 0, 131);
    mem[4] = ins(OP_JMP, 0, 4);
    mem[5] = ins(OP_STORE, 0, 132);
    mem[6] = ins(OP_JMP, 0, 6);
    mem[7] = ins(OP_NOP, 1, 110);
    mem[110] = 16'hF878;
    mem[120] = 16'h1234;
    mem[111] = 16'd130;
    mem[112] = 16'd5;
    mem[131] = 16'h5555;
    doReset();
    runCycles(150);
    check("R4 indirect load then indirect store", 32'(mem[130]), 32'h1234);
    check("R4 indirect jump skips", 32'(mem[131]), 32'h5555);
    check("R4 indirect jump target", 32'(mem[132]), 32'h1234);
    check("R4 R13 indirect code seen", 32'(indCycles > 0), 1);
  endtask

  task automatic testUndefined();
    clearMem();
    waitStates = 0;
    mem[0] = ins(OP_LOAD, 0, 100);
    mem[1] = ins(OP_ADD, 0, 101);
    mem[2] = ins(4'hF, 0, 100);
    mem[3] = ins(OP_NOP, 1, 100);
    mem[4] = ins(4'h9, 1, 101);
    mem[5] = ins(OP_STORE, 0, 150);
    mem[6] = ins(OP_LOAD, 0, 102);
    mem[7] = ins(OP_STORE, 0, 151);
    mem[8] = ins(OP_JMP, 0, 8);
    mem[100] = 16'h7FFF;
    mem[101] = 16'h0001;
    mem[151] = 16'hAAAA;
    doReset();
    runCycles(120);
    check("R12 undefined opcodes keep accumulator", 32'(mem[150]), 32'h8000);
    check("R12 undefined opcodes keep operand", 32'(mem[100]), 32'h7FFF);
    check("R12 load stores zero", 32'(mem[151]), 0);
    check("R12 load and undefined keep flags", 32'(psw), 32'h2C);
    check("R4 undefined opcode never indirect", indCycles, 0);
  endtask

  task automatic testInterrupt();
    int guard;
    clearMem();
    waitStates = 1;
    mem[0] = ins(OP_LOAD, 0, 100);
    mem[1] = ins(OP_JMP, 0, 1);
    mem[HANDLER]     = ins(OP_STORE, 0, 200);
    mem[HANDLER + 1] = ins(OP_STORE, 0, 201);
    mem[HANDLER + 2] = ins(OP_RETI, 0, 0);
    mem[100] = 16'h0042;
    doReset();
    runCycles(30);
    check("R9 no interrupt without request", intEntries, 0);
    irqReq = 1'b1;
    guard = 0;
    while (!(memWe && memReq && memAddr == 11'd201) && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    check("R10 handler store reached", 32'(guard < 500), 1);
    check("R10 handler runs with ie clear, supervisor set", 32'(psw), 32'h40);
    check("R9 held request masked inside handler", intEntries, 1);
    irqReq = 1'b0;
    runCycles(60);
    check("R10 return pc saved", 32'(mem[SAVE]), 1);
    check("R10 handler first store", 32'(mem[200]), 32'h42);
    check("R11 return restores ie and user mode", 32'(psw), 32'h20);
    check("R11 no further entry after return", intEntries, 1);
    irqReq = 1'b1;
    guard = 0;
    while (subcycle != 2'd3 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    irqReq = 1'b0;
    check("R11 interrupts accepted again after return", intEntries, 2);
    runCycles(60);
  endtask

  initial begin
    testReset();
    testBasic(0);
    testBasic(3);
    aluCase("R7 add signed overflow", 16'h7FFF, OP_ADD, 16'h0001, 16'h8000, 5'b01100);
    aluCase("R7 add carry zero overflow equal", 16'h8000, OP_ADD, 16'h8000, 16'h0000, 5'b11011);
    aluCase("R7 sub borrow", 16'd5, OP_SUB, 16'd7, 16'hFFFE, 5'b00101);
    aluCase("R7 sub signed overflow", 16'h8000, OP_SUB, 16'h0001, 16'h7FFF, 5'b01000);
    aluCase("R6 sub equal operands", 16'd9, OP_SUB, 16'd9, 16'h0000, 5'b10010);
    aluCase("R6 and sign", 16'h8003, OP_AND, 16'h8001, 16'h8001, 5'b00100);
    aluCase("R6 and equal", 16'h00FF, OP_AND, 16'h00FF, 16'h00FF, 5'b10000);
    testJumps();
    testIndirect();
    testUndefined();
    testInterrupt();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule